// File: doc/BRIEF.md
# Byte-Serial Register Increment Sequencer

This block is a small fetch-and-execute engine. It walks a byte-wide memory through an instruction pointer, reading one byte per cycle. Each byte is placed in the next slot of a short instruction-register bank. After each byte a completeness test decides one of three things: the instruction is finished, another byte is needed, or the encoding is not supported. Finished instructions are executed in a dedicated cycle against an internal file of eight 16-bit registers.

The supported subset is register increment in two widths. A one-byte form adds one to a full 16-bit register. A two-byte form adds one to a single byte half of one of the first four registers. Any other encoding stops the engine for good and raises a flag. The memory is expected to answer combinationally: `mem_data` must be valid in the same cycle that `mem_rd_n` is low and `mem_addr` is driven. The register file is visible through a combinational observation port.

Top module: `incseq_core`

## Requirements
- R1: In the first cycle after synchronous reset the read strobe is low, the address is 0 (RESET_IP), `illegal` and `retire` are low, and all eight registers read 0000h.
- R2: Each fetch cycle drives the instruction pointer on `mem_addr` with `mem_rd_n` low, and consumes one byte. The pointer advances by one after every byte, including the last byte of an instruction. The strobe is high in execute cycles.
- R3: A single byte 01000rrr adds one, modulo 2^16, to register rrr. The registers in code order are the accumulator 0, the counter 1, the data 2, the base 3, the stack pointer 4, the base pointer 5, the source index 6 and the destination index 7.
- R4: The byte pair FEh then 11000rrr adds one to a byte half. For rrr 0 to 3 it targets the low byte of register rrr. For rrr 4 to 7 it targets the high byte of register rrr-4.
- R5: A byte-half increment wraps from FFh to 00h with no carry, and leaves the other half of the register unchanged.
- R6: A 16-bit increment of FFFFh gives 0000h.
- R7: A first byte that is neither 01000rrr nor FEh sets `illegal` on the following edge. From then on `illegal` stays high, no further reads occur, `mem_addr` holds, and the registers are unchanged.
- R8: FEh followed by a byte whose top five bits are not 11000 sets `illegal` on the edge that latches that second byte.
- R9: `retire` is high for exactly one cycle, the cycle after the last byte of an instruction is read. The register update is visible one cycle later. One-byte instructions take 2 cycles and two-byte instructions take 3.
- R10: The bytes FE C4 46 at consecutive addresses execute as a high-accumulator-byte increment followed by a source-index increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W (20) | Byte address, equal to the instruction pointer |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_data | input | 8 | Byte returned by memory in the same cycle |
| illegal | output | 1 | Sticky halt flag for an unsupported encoding |
| retire | output | 1 | High in the execute cycle of a completed instruction |
| obs_sel | input | 3 | Register code to observe (16-bit code order) |
| obs_data | output | 16 | Combinational content of the selected register |

## Verification
After a one-byte instruction is read, `retire` is high after one edge and the register shows the new value after two. After a two-byte instruction, `retire` is high one edge after the second byte and the update is seen one edge later. `illegal` rises on the edge that latches the offending byte. The bench counts clock edges from reset release, sampling on falling edges. For each program it derives the expected edge count, summing 2 per one-byte, 3 per two-byte, and 1 or 2 for the stopping encoding, and compares it with the edge on which `illegal` first appears. One short program is also traced edge by edge against these offsets.

// File: rtl/incseq_pkg.sv
// Package: shared encodings and state types for the increment sequencer.
// Assumes byte-wide memory and the two fixed increment encodings.
package incseq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } seq_state_t;

    // Decoded operation kinds
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INC16 = 2'd1,
        OP_INC8  = 2'd2
    } inc_op_t;

    localparam logic [4:0] WIDE_TAG    = 5'b01000;  // top bits of one-byte increment
    localparam logic [7:0] NARROW_PFX  = 8'hFE;     // first byte of byte-half increment
    localparam logic [4:0] NARROW_TAG  = 5'b11000;  // top bits of its second byte
    localparam int         NUM_REGS    = 8;         // fixed by the 3-bit register code
    localparam int         NUM_SPLIT   = 4;         // registers with addressable halves

endpackage

// File: rtl/incseq_fetch.sv
// Module: incseq_fetch
// Fetches one byte per cycle at the instruction pointer, stores it in the
// instruction-register bank, and tests completeness after each byte.
// A finished instruction gets one execute cycle; a bad encoding halts.
// Assumes memory returns the byte combinationally in the read cycle.
module incseq_fetch
    import incseq_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                IR_DEPTH = 4,
    parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    input  logic [7:0]        mem_data,
    output logic              exec_valid,
    output inc_op_t           exec_op,
    output logic [2:0]        exec_code,
    output logic              halted
);

    localparam int CNT_W = (IR_DEPTH > 1) ? $clog2(IR_DEPTH) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(IR_DEPTH - 1);

    seq_state_t        st_q;
    logic [ADDR_W-1:0] ip_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        ir_q [IR_DEPTH];
    inc_op_t           op_q;
    logic [2:0]        code_q;

    logic              chk_done;
    logic              chk_bad;
    inc_op_t           chk_op;
    logic [2:0]        chk_code;

    // Completeness test on the byte arriving in this fetch cycle
    always_comb begin
        chk_done = 1'b0;
        chk_bad  = 1'b0;
        chk_op   = OP_NONE;
        chk_code = mem_data[2:0];
        if (cnt_q == '0) begin
            if (mem_data[7:3] == WIDE_TAG) begin
                chk_done = 1'b1;
                chk_op   = OP_INC16;
            end else if (mem_data != NARROW_PFX) begin
                chk_bad = 1'b1;
            end
        end else if (cnt_q == CNT_W'(1) && ir_q[0] == NARROW_PFX) begin
            if (mem_data[7:3] == NARROW_TAG) begin
                chk_done = 1'b1;
                chk_op   = OP_INC8;
            end else begin
                chk_bad = 1'b1;
            end
        end else begin
            chk_bad = 1'b1;
        end
        if (!chk_done && !chk_bad && cnt_q == LAST_SLOT) begin
            chk_bad = 1'b1;
        end
    end

    // Sequencer: latch byte, step pointer, choose next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_FETCH;
            ip_q   <= RESET_IP;
            cnt_q  <= '0;
            op_q   <= OP_NONE;
            code_q <= '0;
            for (int i = 0; i < IR_DEPTH; i++) begin
                ir_q[i] <= '0;
            end
        end else begin
            case (st_q)
                ST_FETCH: begin
                    ir_q[cnt_q] <= mem_data;
                    ip_q        <= ip_q + 1'b1;
                    if (chk_bad) begin
                        st_q <= ST_HALT;
                    end else if (chk_done) begin
                        st_q   <= ST_EXEC;
                        op_q   <= chk_op;
                        code_q <= chk_code;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EXEC: st_q <= ST_FETCH;
                default: st_q <= ST_HALT;
            endcase
        end
    end

    // Port drive from phase and pointer
    always_comb begin
        mem_addr   = ip_q;
        mem_rd_n   = (st_q != ST_FETCH);
        exec_valid = (st_q == ST_EXEC);
        exec_op    = op_q;
        exec_code  = code_q;
        halted     = (st_q == ST_HALT);
    end

endmodule

// File: rtl/incseq_regfile.sv
// Module: incseq_regfile
// Eight REG_W-bit registers. A wide increment adds one to a whole register.
// A narrow increment adds one to the low half (codes 0-3) or the high half
// (codes 4-7) of registers 0-3, with no carry between halves.
// Assumes at most one increment request per cycle.
module incseq_regfile
    import incseq_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_valid,
    input  inc_op_t          inc_op,
    input  logic [2:0]       inc_code,
    input  logic [2:0]       obs_sel,
    output logic [REG_W-1:0] obs_data
);

    localparam int HALF_W = REG_W / 2;

    logic [NUM_REGS-1:0][REG_W-1:0] regs_w;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] r_q;
        logic             hit_wide;
        logic             hit_lo;
        logic             hit_hi;

        assign hit_wide = inc_valid && inc_op == OP_INC16 && inc_code == 3'(g);

        if (g < NUM_SPLIT) begin : g_split
            assign hit_lo = inc_valid && inc_op == OP_INC8 && inc_code == 3'(g);
            assign hit_hi = inc_valid && inc_op == OP_INC8 && inc_code == 3'(g + NUM_SPLIT);
        end else begin : g_whole
            assign hit_lo = 1'b0;
            assign hit_hi = 1'b0;
        end

        // Register update: whole-word or independent half increment
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (hit_wide) begin
                r_q <= r_q + 1'b1;
            end else begin
                if (hit_lo) r_q[HALF_W-1:0]     <= r_q[HALF_W-1:0] + 1'b1;
                if (hit_hi) r_q[REG_W-1:HALF_W] <= r_q[REG_W-1:HALF_W] + 1'b1;
            end
        end

        assign regs_w[g] = r_q;
    end

    // Observation read mux
    always_comb obs_data = regs_w[obs_sel];

endmodule

// File: rtl/incseq_core.sv
// Module: incseq_core (top)
// Joins the byte fetcher and the register file. Retire marks the execute
// cycle; illegal marks a permanent halt on an unsupported encoding.
// Assumes a combinational byte memory on mem_addr/mem_data.
module incseq_core
    import incseq_pkg::*;
#(
    parameter int                ADDR_W   = 20,
    parameter int                IR_DEPTH = 4,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_IP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    input  logic [7:0]        mem_data,
    output logic              illegal,
    output logic              retire,
    input  logic [2:0]        obs_sel,
    output logic [REG_W-1:0]  obs_data
);

    logic       exec_valid;
    inc_op_t    exec_op;
    logic [2:0] exec_code;
    logic       halted;

    incseq_fetch #(
        .ADDR_W  (ADDR_W),
        .IR_DEPTH(IR_DEPTH),
        .RESET_IP(RESET_IP)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd_n  (mem_rd_n),
        .mem_data  (mem_data),
        .exec_valid(exec_valid),
        .exec_op   (exec_op),
        .exec_code (exec_code),
        .halted    (halted)
    );

    incseq_regfile #(
        .REG_W(REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_valid(exec_valid),
        .inc_op   (exec_op),
        .inc_code (exec_code),
        .obs_sel  (obs_sel),
        .obs_data (obs_data)
    );

    // Status outputs
    always_comb begin
        illegal = halted;
        retire  = exec_valid;
    end

endmodule

// File: rtl/incseq_core_chk.sv
// Module: incseq_core_chk
// Port-level protocol properties for incseq_core, attached by bind.
module incseq_core_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic              illegal,
    input logic              retire
);

    // R2: back-to-back reads step the address by one
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && $past(!mem_rd_n && rst_n)) |-> mem_addr == $past(mem_addr) + 1'b1);

    // R7: halt is sticky
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    // R7: no reads while halted
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> mem_rd_n);

    // R7: address frozen while halted
    p_halt_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && $past(illegal)) |-> $stable(mem_addr));

    // R9: retire lasts a single cycle
    p_retire_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R9: retire follows a read cycle and is not a read itself
    p_retire_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (mem_rd_n && !illegal && $past(!mem_rd_n)));

endmodule

bind incseq_core incseq_core_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_addr(mem_addr),
    .mem_rd_n(mem_rd_n),
    .illegal (illegal),
    .retire  (retire)
);

// File: tb/test_incseq_core.sv
module test_incseq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] mem_addr;
    logic        mem_rd_n;
    logic [7:0]  mem_data;
    logic        illegal;
    logic        retire;
    logic [2:0]  obs_sel = '0;
    logic [15:0] obs_data;

    logic [7:0]  mem [4096];
    logic [15:0] em [8];
    int          wp;
    int          n_checks = 0;
    int          n_errors = 0;
    int          tick = 0;

    always #5 clk = ~clk;

    assign mem_data = mem[mem_addr[11:0]];

    incseq_core i_incseq_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_addr(mem_addr),
        .mem_rd_n(mem_rd_n),
        .mem_data(mem_data),
        .illegal (illegal),
        .retire  (retire),
        .obs_sel (obs_sel),
        .obs_data(obs_data)
    );

    // Watchdog
    always @(posedge clk) begin
        tick++;
        if (tick > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", tick);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h90;
        wp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        mem[wp] = b;
        wp++;
    endtask

    // Arithmetic model of the program in mem: expected registers and edges to halt
    task automatic model(output int ecyc);
        int ptr = 0;
        logic [7:0] b, b2;
        int k;
        ecyc = 0;
        for (int i = 0; i < 8; i++) em[i] = 16'h0000;
        while (1) begin
            b = mem[ptr];
            if (b[7:3] == 5'b01000) begin
                em[b[2:0]] = em[b[2:0]] + 16'h1;
                ecyc += 2;
                ptr  += 1;
            end else if (b == 8'hFE) begin
                b2 = mem[ptr + 1];
                if (b2[7:3] == 5'b11000) begin
                    k = int'(b2[2:0]);
                    if (k < 4) em[k][7:0] = em[k][7:0] + 8'h1;
                    else       em[k-4][15:8] = em[k-4][15:8] + 8'h1;
                    ecyc += 3;
                    ptr  += 2;
                end else begin
                    ecyc += 2;
                    break;
                end
            end else begin
                ecyc += 1;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic read_reg(input int r, output logic [15:0] v);
        obs_sel = 3'(r);
        #1;
        v = obs_data;
    endtask

    // Run the loaded program to its halt and compare edge count and registers
    task automatic run_prog(input string tag);
        int ecyc;
        int cyc = 0;
        logic [15:0] v;
        model(ecyc);
        do_reset();
        while (!illegal && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " R9 halt edge"}, 32'(cyc), 32'(ecyc));
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            chk({tag, " reg"}, {16'h0, v}, {16'h0, em[r]});
        end
    endtask

    initial begin
        logic [15:0] v;

        // S1: reset state and edge-by-edge trace of 40 FE C1 90
        clear_mem();
        put(8'h40); put(8'hFE); put(8'hC1); put(8'h90);
        do_reset();
        chk("R1 rd_n", 32'(mem_rd_n), 32'd0);
        chk("R1 addr", 32'(mem_addr), 32'd0);
        chk("R1 illegal", 32'(illegal), 32'd0);
        chk("R1 retire", 32'(retire), 32'd0);
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            chk("R1 reg zero", 32'(v), 32'd0);
        end
        @(negedge clk);
        chk("R9 retire after 1-byte", 32'(retire), 32'd1);
        chk("R2 strobe high in exec", 32'(mem_rd_n), 32'd1);
        @(negedge clk);
        read_reg(0, v);
        chk("R3 AX updated", 32'(v), 32'd1);
        chk("R2 addr after 1-byte", 32'(mem_addr), 32'd1);
        chk("R2 strobe low", 32'(mem_rd_n), 32'd0);
        @(negedge clk);
        chk("R2 addr second byte", 32'(mem_addr), 32'd2);
        chk("R9 no retire mid", 32'(retire), 32'd0);
        @(negedge clk);
        chk("R9 retire after 2-byte", 32'(retire), 32'd1);
        @(negedge clk);
        read_reg(1, v);
        chk("R4 CL updated", 32'(v), 32'h0001);
        chk("R2 addr past last byte", 32'(mem_addr), 32'd3);
        @(negedge clk);
        chk("R7 illegal raised", 32'(illegal), 32'd1);
        chk("R7 no read", 32'(mem_rd_n), 32'd1);
        repeat (5) @(negedge clk);
        chk("R7 illegal sticky", 32'(illegal), 32'd1);
        chk("R7 addr held", 32'(mem_addr), 32'd4);

        // S2: sweep every wide and narrow code, then the FE C4 46 pair
        clear_mem();
        for (int r = 0; r < 8; r++)
            for (int n = 0; n <= r; n++) put(8'h40 + 8'(r));
        for (int c = 0; c < 8; c++) begin
            put(8'hFE); put(8'hC0 + 8'(c));
        end
        put(8'hFE); put(8'hC4); put(8'h46);
        run_prog("R3 R4 R10 sweep");

        // S3: R10 alone
        clear_mem();
        put(8'hFE); put(8'hC4); put(8'h46);
        run_prog("R10 pair");

        // S4: byte wrap with untouched high half, and 16-bit wrap
        clear_mem();
        put(8'hFE); put(8'hC4);
        for (int n = 0; n < 256; n++) begin put(8'hFE); put(8'hC0); end
        for (int n = 0; n < 255; n++) begin put(8'hFE); put(8'hC3); end
        for (int n = 0; n < 255; n++) begin put(8'hFE); put(8'hC7); end
        put(8'h43);
        put(8'hFF);
        run_prog("R5 R6 wrap");
        read_reg(0, v);
        chk("R5 AX after low wrap", 32'(v), 32'h0100);
        read_reg(3, v);
        chk("R6 BX wrapped", 32'(v), 32'h0000);

        // S5: bad second byte after FE
        clear_mem();
        put(8'h42); put(8'hFE); put(8'h05); put(8'h40);
        run_prog("R8 bad second");
        repeat (4) @(negedge clk);
        read_reg(0, v);
        chk("R8 AX untouched after halt", 32'(v), 32'h0000);

        // S6: unsupported first byte, later increments never run
        clear_mem();
        put(8'h48); put(8'h40); put(8'h40);
        run_prog("R7 bad first");
        repeat (6) @(negedge clk);
        read_reg(0, v);
        chk("R7 AX unchanged", 32'(v), 32'h0000);
        chk("R7 addr frozen", 32'(mem_addr), 32'd1);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule